// File: doc/BRIEF.md
# Overlapping 0110 Combination Lock

This block is a lock controller with two keys, "0" and "1". Each key press reaches it as a pulse lasting one clock cycle. The unlock output goes high exactly when the four most recent accepted presses, from oldest to newest, are 0, 1, 1, 0. There is no start key. Matching overlaps, so the tail of one successful entry can begin the next one.

Inside is a Moore machine with five reachable states held in three flip-flops:

- nothing matched;
- "0" matched;
- "01" matched;
- "011" matched;
- open.

The other three encodings are never entered in normal use. Flip-flops can wake up holding any value, so every unused encoding also has defined exits: a "0" press goes to the "0 matched" state and a "1" press goes to the "nothing matched" state. Five states is the minimum, because four presses need four transitions to reach the open state.

Reset is optional and active low. It loads the encoding given by the `INIT_CODE` parameter, which defaults to "nothing matched". A cycle with no press, or with both keys pressed together, is not a press.

Top module: `seq_lock`

## Requirements
- R1: While `rstN` is low, the state register loads `INIT_CODE`. The default is 3'd0 ("nothing matched"), so `unlock` is 0 after a default reset.
- R2: The state encodings are nothing=3'd0, "0"=3'd1, "01"=3'd2, "011"=3'd3 and open=3'd4. After an accepted press, `unlock` is 1 from the next clock edge exactly when the last four accepted presses, oldest first, were 0,1,1,0.
- R3: Matching overlaps. From the open state, a "1" press moves to the "01" state and a "0" press moves to the "0" state. So 0110 followed by 110 unlocks a second time.
- R4: A cycle with neither key or with both keys leaves the state unchanged. This holds `unlock` at its value and keeps any partial match.
- R5: From any of the unused encodings 3'd5, 3'd6 and 3'd7, a "0" press moves to the "0" state.
- R6: From any unused encoding, a "1" press moves to the "nothing matched" state.
- R7: `unlock` is 0 while the state holds an unused encoding.
- R8: From the "011" state, a "1" press moves to the "nothing matched" state.
- R9: From the "01" state, a "0" press moves to the "0" state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low, loads INIT_CODE; tie high if unused |
| pressZero | input | 1 | One-cycle pulse for a press of key "0" |
| pressOne | input | 1 | One-cycle pulse for a press of key "1" |
| unlock | output | 1 | High while the last four presses were 0,1,1,0 |

## Verification
The bench builds four copies of the lock side by side. One uses the default `INIT_CODE` of 3'd0. The other three use 3'd5, 3'd6 and 3'd7. Reset is the only way to place the machine in an unused encoding, so these three copies make the recovery arcs and the output of unused states reachable from the ports. The same press sequences drive all four copies. This separates a "0" exit from a "1" exit by whether a following 1,1,0 unlocks.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;
  localparam int STATE_W   = 3;
  localparam int MATCH_LEN = 4;
  localparam int CNT_W     = $clog2(MATCH_LEN + 1);
  localparam logic [MATCH_LEN-1:0] MATCH_PAT = 4'b0110;

  typedef logic [STATE_W-1:0] code_t;

  localparam code_t ST_IDLE   = 3'd0;
  localparam code_t ST_GOT0   = 3'd1;
  localparam code_t ST_GOT01  = 3'd2;
  localparam code_t ST_GOT011 = 3'd3;
  localparam code_t ST_OPEN   = 3'd4;

  // Strobes from the key qualifier to the state datapath
  typedef struct packed {
    logic step;    // exactly one key pressed this cycle
    logic bitOne;  // value of that key
  } strobe_t;
endpackage

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seq_lock_pkg::*;
(
  input  logic    pressZero,
  input  logic    pressOne,
  output strobe_t strb
);
  // Two keys at once are ambiguous and count as no press (R4)
  always_comb begin
    strb.step   = pressZero ^ pressOne;
    strb.bitOne = pressOne;
  end
endmodule

// File: rtl/seq_lock_dp.sv
module seq_lock_dp
  import seq_lock_pkg::*;
#(
  parameter code_t INIT_CODE = ST_IDLE
)(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output logic    unlock
);
  code_t curState;
  code_t nextState;

  always_comb begin
    nextState = curState;
    if (strb.step) begin
      case (curState)
        ST_IDLE:   nextState = strb.bitOne ? ST_IDLE   : ST_GOT0;
        ST_GOT0:   nextState = strb.bitOne ? ST_GOT01  : ST_GOT0;
        ST_GOT01:  nextState = strb.bitOne ? ST_GOT011 : ST_GOT0;
        ST_GOT011: nextState = strb.bitOne ? ST_IDLE   : ST_OPEN;
        ST_OPEN:   nextState = strb.bitOne ? ST_GOT01  : ST_GOT0;
        default:   nextState = strb.bitOne ? ST_IDLE   : ST_GOT0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= INIT_CODE;
    else       curState <= nextState;
  end

  assign unlock = (curState == ST_OPEN);

  // Independent record of accepted presses, for checking only
  logic [MATCH_LEN-1:0] histBits;
  logic [CNT_W-1:0]     histCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histBits <= '0;
      histCnt  <= '0;
    end else if (strb.step) begin
      histBits <= {histBits[MATCH_LEN-2:0], strb.bitOne};
      if (histCnt != CNT_W'(MATCH_LEN)) histCnt <= histCnt + CNT_W'(1);
    end
  end

  // R2
  pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    (histCnt == CNT_W'(MATCH_LEN)) |-> (unlock == (histBits == MATCH_PAT)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> $stable(curState));

  // R5
  legal_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (curState <= ST_OPEN));

  // R8
  drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.bitOne && curState == ST_GOT011) |=> (curState == ST_IDLE));

  // R3
  overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.bitOne && curState == ST_OPEN) |=> (curState == ST_GOT01));

  // R9
  reprefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.bitOne && curState == ST_GOT01) |=> (curState == ST_GOT0));
endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
#(
  parameter code_t INIT_CODE = ST_IDLE
)(
  input  logic clk,
  input  logic rstN,
  input  logic pressZero,
  input  logic pressOne,
  output logic unlock
);
  strobe_t strb;

  seq_lock_ctrl ctrl_i (
    .pressZero (pressZero),
    .pressOne  (pressOne),
    .strb      (strb)
  );

  seq_lock_dp #(.INIT_CODE(INIT_CODE)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .unlock (unlock)
  );
endmodule

// File: tb/seq_lock_tb_top.sv
module seq_lock_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pressZero = 1'b0;
  logic pressOne = 1'b0;
  logic unlock, unlockU5, unlockU6, unlockU7;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seq_lock dut_i (.clk(clk), .rstN(rstN), .pressZero(pressZero), .pressOne(pressOne), .unlock(unlock));
  seq_lock #(.INIT_CODE(3'd5)) dutU5_i (.clk(clk), .rstN(rstN), .pressZero(pressZero), .pressOne(pressOne), .unlock(unlockU5));
  seq_lock #(.INIT_CODE(3'd6)) dutU6_i (.clk(clk), .rstN(rstN), .pressZero(pressZero), .pressOne(pressOne), .unlock(unlockU6));
  seq_lock #(.INIT_CODE(3'd7)) dutU7_i (.clk(clk), .rstN(rstN), .pressZero(pressZero), .pressOne(pressOne), .unlock(unlockU7));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  // One press; state has updated at the posedge before return
  task automatic press(input logic b);
    @(negedge clk); pressZero = !b; pressOne = b;
    @(negedge clk); pressZero = 1'b0; pressOne = 1'b0;
  endtask

  task automatic pressBoth();
    @(negedge clk); pressZero = 1'b1; pressOne = 1'b1;
    @(negedge clk); pressZero = 1'b0; pressOne = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 reset default", unlock, 1'b0);
    chk("R7 unused 5 output", unlockU5, 1'b0);
    chk("R7 unused 6 output", unlockU6, 1'b0);
    chk("R7 unused 7 output", unlockU7, 1'b0);
  endtask

  task automatic testBasic();
    doReset();
    press(0); chk("R2 after 0", unlock, 1'b0);
    press(1); chk("R2 after 01", unlock, 1'b0);
    press(1); chk("R2 after 011", unlock, 1'b0);
    press(0); chk("R2 after 0110", unlock, 1'b1);
    press(1); chk("R2 after 01101", unlock, 1'b0);
    press(0); chk("R2 after 011010", unlock, 1'b0);
    doReset(); chk("R1 reset after use", unlock, 1'b0);
  endtask

  task automatic testOverlap();
    doReset();
    press(0); press(1); press(1); press(0);
    chk("R3 first open", unlock, 1'b1);
    press(1); chk("R3 open+1", unlock, 1'b0);
    press(1); chk("R3 open+11", unlock, 1'b0);
    press(0); chk("R3 second open", unlock, 1'b1);
    press(0); chk("R3 open+0", unlock, 1'b0);
  endtask

  task automatic testReprefix();
    doReset();
    press(0); press(1); press(0);
    chk("R9 after 010", unlock, 1'b0);
    press(1); press(1);
    chk("R9 after 01011", unlock, 1'b0);
    press(0);
    chk("R9 after 010110", unlock, 1'b1);
  endtask

  task automatic testDrop();
    doReset();
    press(0); press(1); press(1); press(1);
    chk("R8 after 0111", unlock, 1'b0);
    press(0);
    chk("R8 after 01110", unlock, 1'b0);
    doReset();
    press(0); press(1); press(1); press(1);
    press(1); press(1); press(0);
    chk("R8 0111 then 110", unlock, 1'b0);
    press(1); press(1); press(0);
    chk("R8 recovers with 0110", unlock, 1'b1);
  endtask

  task automatic testHold();
    doReset();
    press(0); press(1); press(1);
    idle(3);
    chk("R4 idle keeps partial", unlock, 1'b0);
    pressBoth(); pressBoth();
    chk("R4 both keys ignored", unlock, 1'b0);
    press(0);
    chk("R4 partial kept through idle/both", unlock, 1'b1);
    idle(4);
    chk("R4 idle holds unlock", unlock, 1'b1);
    pressBoth();
    chk("R4 both holds unlock", unlock, 1'b1);
  endtask

  task automatic testRecovery();
    doReset();
    press(0);
    chk("R5 unused 5 after 0", unlockU5, 1'b0);
    press(1); press(1); press(0);
    chk("R5 unused 5 via 0", unlockU5, 1'b1);
    chk("R5 unused 6 via 0", unlockU6, 1'b1);
    chk("R5 unused 7 via 0", unlockU7, 1'b1);
    doReset();
    press(1); press(1); press(1); press(0);
    chk("R6 unused 5 via 1", unlockU5, 1'b0);
    chk("R6 unused 6 via 1", unlockU6, 1'b0);
    chk("R6 unused 7 via 1", unlockU7, 1'b0);
    doReset();
    idle(3); pressBoth();
    chk("R7 unused 5 held", unlockU5, 1'b0);
    chk("R7 unused 6 held", unlockU6, 1'b0);
    press(0); press(1); press(1);
    chk("R7 unused 7 partial", unlockU7, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testBasic();
    testOverlap();
    testReprefix();
    testDrop();
    testHold();
    testRecovery();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule